// File: doc/BRIEF.md
# Sprite Overlay Renderer

This block draws a small, fixed set of hardware sprites over a stream of video pixels. Each pixel arrives as a 40-bit word with its horizontal and vertical screen coordinates and a 2-bit sync sideband. The block works out which sprites cover that coordinate and reads each covering sprite's pixel from that sprite's own 4 KB image cache. It then sends out either the original pixel or the pixel of the lowest-numbered sprite that is opaque at that spot. Software sets each sprite through a 32-bit register write port: position, size, horizontal and vertical magnification, pixel format, image start offset and enable. It fills the image caches through a separate 32-bit word write port.

The video path is a two-stage valid/ready pipeline under a single stall condition. The pipeline advances when the output holds nothing or the output is accepted. `in_ready` equals that condition, so a pixel is taken only in a cycle in which the whole pipeline moves. When `out_ready` is low while `out_valid` is high, the output word and its sync stay frozen and no new pixel enters. A pixel and its sync appear at the output two advancing cycles after they are accepted.

Pixel word layout: bits 39:36 depth (Z), 35:24 red, 23:12 green, 11:0 blue. The sprite count `NSPR` must be one of 1, 2, 4, 6, 8, 10, 14, 16 or 32. Any other value stops elaboration.

Top module: `sprite_overlay`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `out_valid` is low and `in_ready` is high. Every sprite starts disabled.
- R2: A pixel accepted with `in_valid && in_ready` appears on `out_pixel`/`out_sync` with `out_valid` high after two advancing clock edges. The sync bits travel unchanged with their pixel.
- R3: While `out_valid` is high and `out_ready` is low, `out_pixel`, `out_sync` and `out_valid` hold their values and `in_ready` is low.
- R4: Where no enabled sprite is opaque at the pixel's coordinate, `out_pixel` equals `in_pixel` bit for bit.
- R5: A sprite covers (h,v) when x ≤ h < x + W·MH and y ≤ v < y + H·MV. W and H are the 8-bit size fields plus one (1..256). MH and MV are the 4-bit magnification fields plus one (1..16).
- R6: The covered image pixel is col = (h−x)/MH and row = (v−y)/MV, with index = row·W + col. Its byte address is (offset + index·B) mod 4096, where B is 1, 2 or 4 bytes. Word address = byte address bits 11:2. Bytes and 16-bit halves sit little-endian in the word.
- R7: Format code 0 is 8-bit R3G3B2 (red 7:5, green 4:2, blue 1:0). Code 1 is 16-bit A1R5G5B5 (red 14:10, green 9:5, blue 4:0). Code 2 is 32-bit A8R8G8B8 (red 23:16, green 15:8, blue 7:0). A sprite with code 3 draws nothing.
- R8: A 16-bit pixel with bit 15 clear and a 32-bit pixel with bit 31 clear are transparent. 8-bit pixels are always opaque.
- R9: A drawn pixel's colour channels are widened to 12 bits by repeating the channel's bits from the top. The output Z field is 4'hF.
- R10: Where several sprites are opaque, the lowest sprite index wins.
- R11: Register address = {sprite[4:0], reg[1:0]}. Reg 0: x in 11:0, y in 27:16. Reg 1: W−1 in 7:0, H−1 in 15:8, MH−1 in 19:16, MV−1 in 23:20. Reg 2: offset in 11:0, format in 17:16, enable in 31. Writes to reg 3, or to a sprite index ≥ NSPR, change nothing.
- R12: `cache_we` writes `cache_wdata` to word `cache_addr` of the cache of sprite `cache_sel`. Pixels accepted after the write read the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | {sprite, register} address |
| reg_wdata | input | 32 | Register write data |
| cache_we | input | 1 | Image cache write strobe |
| cache_sel | input | 5 | Sprite whose cache is written |
| cache_addr | input | 10 | Cache word address |
| cache_wdata | input | 32 | Cache write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted this cycle if valid |
| in_pixel | input | 40 | Input pixel, Z/R/G/B |
| in_hpos | input | 12 | Horizontal coordinate of the input pixel |
| in_vpos | input | 12 | Vertical coordinate of the input pixel |
| in_sync | input | 2 | Sync sideband carried with the pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pixel | output | 40 | Output pixel, Z/R/G/B |
| out_sync | output | 2 | Sync sideband of the output pixel |

## Verification
The bench probes the last column and row inside a magnified sprite and the first ones outside it. A coverage test that is off by one, or that divides by the magnification the wrong way, shows a sprite pixel where the video should pass, or the reverse. It places a sprite 256 pixels wide and starts an image four bytes before the end of the cache. This catches a width field read without its plus-one and an address that does not wrap to word 0. It stacks two sprites with the front one transparent in one place and opaque in another. Reversed priority, or a transparency flag that is ignored, then draws the wrong colour. It also holds `out_ready` low to catch a pipeline that loses or changes a stalled pixel, and writes to unused register slots to catch a decoder that aliases them onto live fields.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int unsigned PIX_W      = 40;
  localparam int unsigned COORD_W    = 12;
  localparam int unsigned RGB_W      = 36;
  localparam int unsigned CACHE_BYTES = 4096;
  localparam int unsigned CACHE_WORDS = CACHE_BYTES / 4;
  localparam int unsigned CW_AW      = $clog2(CACHE_WORDS);
  localparam int unsigned SEL_W      = 5;
  localparam int unsigned RA_W       = SEL_W + 2;

  localparam logic [1:0] FMT_8  = 2'd0;
  localparam logic [1:0] FMT_16 = 2'd1;
  localparam logic [1:0] FMT_32 = 2'd2;
  localparam logic [1:0] FMT_NONE = 2'd3;

  typedef struct packed {
    logic        en;
    logic [1:0]  fmt;
    logic [11:0] offs;
    logic [3:0]  vmag_m1;
    logic [3:0]  hmag_m1;
    logic [7:0]  h_m1;
    logic [7:0]  w_m1;
    logic [11:0] y;
    logic [11:0] x;
  } spr_cfg_t;
endpackage

// File: rtl/spr_regs.sv
module spr_regs
  import spr_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RA_W-1:0] addr,
  input  logic [31:0]     wdata,
  output spr_cfg_t        cfg
);
  logic hit;
  assign hit = we && (addr[RA_W-1:2] == SEL_W'(IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (hit) begin
      case (addr[1:0])
        2'd0: begin
          cfg.x <= wdata[11:0];
          cfg.y <= wdata[27:16];
        end
        2'd1: begin
          cfg.w_m1    <= wdata[7:0];
          cfg.h_m1    <= wdata[15:8];
          cfg.hmag_m1 <= wdata[19:16];
          cfg.vmag_m1 <= wdata[23:20];
        end
        2'd2: begin
          cfg.offs <= wdata[11:0];
          cfg.fmt  <= wdata[17:16];
          cfg.en   <= wdata[31];
        end
        default: ;
      endcase
    end
  end

  // R11: the spare slot leaves the sprite configuration untouched
  assert_spare_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[1:0] == 2'd3) |=> $stable(cfg));
endmodule

// File: rtl/spr_unit.sv
module spr_unit
  import spr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  spr_cfg_t           cfg,
  input  logic [COORD_W-1:0] hpos,
  input  logic [COORD_W-1:0] vpos,
  input  logic               cwe,
  input  logic [CW_AW-1:0]   caddr,
  input  logic [31:0]        cdata,
  output logic               draw,
  output logic [RGB_W-1:0]   rgb
);
  function automatic logic [11:0] div_mag(input logic [11:0] n, input logic [4:0] d);
    logic [12:0] r;
    logic [11:0] q;
    r = '0;
    q = '0;
    for (int i = 11; i >= 0; i--) begin
      r = {r[11:0], n[i]};
      if (r >= {8'd0, d}) begin
        r = r - {8'd0, d};
        q[i] = 1'b1;
      end
    end
    return q;
  endfunction

  logic [11:0] dx, dy, col, row;
  logic [8:0]  wid, hgt;
  logic [16:0] idx;
  logic [11:0] boff, baddr;
  logic        hit_c;

  always_comb begin
    dx  = hpos - cfg.x;
    dy  = vpos - cfg.y;
    col = div_mag(dx, {1'b0, cfg.hmag_m1} + 5'd1);
    row = div_mag(dy, {1'b0, cfg.vmag_m1} + 5'd1);
    wid = {1'b0, cfg.w_m1} + 9'd1;
    hgt = {1'b0, cfg.h_m1} + 9'd1;
    hit_c = cfg.en && (cfg.fmt != FMT_NONE) && (hpos >= cfg.x) && (vpos >= cfg.y)
            && (col < {3'd0, wid}) && (row < {3'd0, hgt});
    idx = {9'd0, row[7:0]} * {8'd0, wid} + {9'd0, col[7:0]};
    case (cfg.fmt)
      FMT_16:  boff = {idx[10:0], 1'b0};
      FMT_32:  boff = {idx[9:0], 2'b00};
      default: boff = idx[11:0];
    endcase
    baddr = cfg.offs + boff;
  end

  logic [31:0] mem [CACHE_WORDS];
  logic [31:0] rd_q;

  always_ff @(posedge clk) begin
    if (cwe) mem[caddr] <= cdata;
    if (adv) rd_q <= mem[baddr[11:2]];
  end

  logic       hit_q;
  logic [1:0] lane_q;
  logic [1:0] fmt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      lane_q <= '0;
      fmt_q  <= FMT_NONE;
    end else if (adv) begin
      hit_q  <= hit_c;
      lane_q <= baddr[1:0];
      fmt_q  <= cfg.fmt;
    end
  end

  logic [7:0]  b8;
  logic [15:0] h16;
  logic        opaque;

  always_comb begin
    b8  = rd_q[8*lane_q +: 8];
    h16 = lane_q[1] ? rd_q[31:16] : rd_q[15:0];
    opaque = 1'b0;
    rgb = '0;
    case (fmt_q)
      FMT_8: begin
        opaque = 1'b1;
        rgb = {{4{b8[7:5]}}, {4{b8[4:2]}}, {6{b8[1:0]}}};
      end
      FMT_16: begin
        opaque = h16[15];
        rgb = {h16[14:10], h16[14:10], h16[14:13],
               h16[9:5],   h16[9:5],   h16[9:8],
               h16[4:0],   h16[4:0],   h16[4:3]};
      end
      FMT_32: begin
        opaque = rd_q[31];
        rgb = {rd_q[23:16], rd_q[23:20], rd_q[15:8], rd_q[15:12], rd_q[7:0], rd_q[7:4]};
      end
      default: ;
    endcase
    draw = hit_q && opaque;
  end

  // R7: a sprite set to the null format draws nothing in the next stage
  assert_null_fmt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cfg.fmt == FMT_NONE) |=> !draw);
endmodule

// File: rtl/spr_prio.sv
module spr_prio
  import spr_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          draw,
  input  logic [N-1:0][RGB_W-1:0] rgb,
  output logic                  hit,
  output logic [RGB_W-1:0]      rgb_o
);
  logic [N-1:0] win;

  always_comb begin
    win   = '0;
    rgb_o = '0;
    hit   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (draw[i]) begin
        win    = '0;
        win[i] = 1'b1;
        rgb_o  = rgb[i];
        hit    = 1'b1;
      end
    end
  end

  // R10: one winner at most, and no drawing sprite with a lower index than it
  assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win) && ((win & draw) == win) && (((win - N'(1)) & draw) == '0));
endmodule

// File: rtl/sprite_overlay.sv
module sprite_overlay
  import spr_pkg::*;
#(
  parameter int unsigned NSPR = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [6:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic               cache_we,
  input  logic [4:0]         cache_sel,
  input  logic [9:0]         cache_addr,
  input  logic [31:0]        cache_wdata,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [39:0]        in_pixel,
  input  logic [11:0]        in_hpos,
  input  logic [11:0]        in_vpos,
  input  logic [1:0]         in_sync,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [39:0]        out_pixel,
  output logic [1:0]         out_sync
);
  generate
    if (!(NSPR == 1 || NSPR == 2 || NSPR == 4 || NSPR == 6 || NSPR == 8 ||
          NSPR == 10 || NSPR == 14 || NSPR == 16 || NSPR == 32)) begin : g_bad_count
      $error("sprite_overlay: unsupported sprite count");
    end
  endgenerate

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  logic               s1_valid;
  logic [PIX_W-1:0]   s1_pixel;
  logic [1:0]         s1_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_pixel <= '0;
      s1_sync  <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_pixel <= in_pixel;
      s1_sync  <= in_sync;
    end
  end

  logic [NSPR-1:0]            draw;
  logic [NSPR-1:0][RGB_W-1:0] rgb;

  for (genvar g = 0; g < NSPR; g++) begin : g_spr
    spr_cfg_t cfg;
    logic     cwe;
    assign cwe = cache_we && (cache_sel == SEL_W'(g));

    spr_regs #(.IDX(g)) i_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .cfg(cfg)
    );

    spr_unit i_unit (
      .clk(clk), .rst_n(rst_n), .adv(adv), .cfg(cfg),
      .hpos(in_hpos), .vpos(in_vpos),
      .cwe(cwe), .caddr(cache_addr), .cdata(cache_wdata),
      .draw(draw[g]), .rgb(rgb[g])
    );
  end

  logic             any_hit;
  logic [RGB_W-1:0] win_rgb;

  spr_prio #(.N(NSPR)) i_prio (
    .clk(clk), .rst_n(rst_n), .draw(draw), .rgb(rgb),
    .hit(any_hit), .rgb_o(win_rgb)
  );

  logic out_drawn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
      out_sync  <= '0;
      out_drawn <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_valid;
      out_pixel <= any_hit ? {4'hF, win_rgb} : s1_pixel;
      out_sync  <= s1_sync;
      out_drawn <= any_hit;
    end
  end

  // R3: a stalled output word stays put
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel) && $stable(out_sync)));

  // R2: an accepted pixel moves into the first stage, then to the output
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> s1_valid);
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && adv) |=> out_valid);

  // R9: drawn pixels carry the nearest depth code
  assert_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_drawn) |-> (out_pixel[39:36] == 4'hF));
endmodule

// File: tb/test_sprite_overlay.sv
module test_sprite_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        cache_we = 1'b0;
  logic [4:0]  cache_sel = '0;
  logic [9:0]  cache_addr = '0;
  logic [31:0] cache_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [39:0] in_pixel = '0;
  logic [11:0] in_hpos = '0;
  logic [11:0] in_vpos = '0;
  logic [1:0]  in_sync = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [39:0] out_pixel;
  logic [1:0]  out_sync;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [39:0] VID = 40'h3_123_456_789;

  always #2.5 clk = ~clk;

  sprite_overlay #(.NSPR(2)) i_sprite_overlay (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .cache_we(cache_we), .cache_sel(cache_sel), .cache_addr(cache_addr), .cache_wdata(cache_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel), .in_hpos(in_hpos),
    .in_vpos(in_vpos), .in_sync(in_sync), .out_valid(out_valid), .out_ready(out_ready),
    .out_pixel(out_pixel), .out_sync(out_sync)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int s, input int r, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {5'(s), 2'(r)}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr_cache(input int s, input int a, input logic [31:0] d);
    @(negedge clk);
    cache_we = 1'b1; cache_sel = 5'(s); cache_addr = 10'(a); cache_wdata = d;
    @(negedge clk);
    cache_we = 1'b0;
  endtask

  task automatic setup(input int s, input int x, input int y, input int wm1, input int hm1,
                       input int mh1, input int mv1, input int fmt, input int offs, input bit en);
    wr_reg(s, 0, {4'd0, 12'(y), 4'd0, 12'(x)});
    wr_reg(s, 1, {8'd0, 4'(mv1), 4'(mh1), 8'(hm1), 8'(wm1)});
    wr_reg(s, 2, {en, 13'd0, 2'(fmt), 4'd0, 12'(offs)});
  endtask

  // Send one pixel and sample the output two edges later (R2)
  task automatic pix(input int h, input int v, input logic [1:0] s);
    @(negedge clk);
    in_valid = 1'b1; in_hpos = 12'(h); in_vpos = 12'(v); in_pixel = VID; in_sync = s;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 out_valid after reset", {39'd0, out_valid}, 40'd0);
    chk("R1 in_ready after reset", {39'd0, in_ready}, 40'd1);
  endtask

  task automatic t_passthrough;
    pix(40, 40, 2'b10);
    chk("R4 disabled sprites pass video", out_pixel, VID);
    chk("R2 sync travels with pixel", {38'd0, out_sync}, 40'd2);
    chk("R2 output valid", {39'd0, out_valid}, 40'd1);
  endtask

  task automatic t_fmt16;
    setup(0, 10, 20, 3, 1, 0, 0, 1, 8, 1'b1);
    wr_cache(0, 5, 32'h0000_FC1F);
    pix(12, 21, 2'b00);
    chk("R9 16-bit opaque pixel widened", out_pixel, {4'hF, 12'hFFF, 12'h000, 12'hFFF});
    pix(13, 21, 2'b00);
    chk("R8 16-bit transparent passes video", out_pixel, VID);
    pix(14, 21, 2'b00);
    chk("R5 right of sprite", out_pixel, VID);
    pix(9, 21, 2'b00);
    chk("R5 left of sprite", out_pixel, VID);
    pix(12, 22, 2'b00);
    chk("R5 below sprite", out_pixel, VID);
  endtask

  task automatic t_fmt8_mag;
    setup(1, 100, 50, 7, 3, 2, 1, 0, 256, 1'b1);
    wr_cache(1, 66, 32'h00A5_0000);
    wr_cache(1, 71, 32'hFF00_0000);
    pix(107, 53, 2'b00);
    chk("R6 magnified 8-bit lane 2", out_pixel, {4'hF, 12'hB6D, 12'h249, 12'h555});
    pix(123, 57, 2'b00);
    chk("R5 last magnified column and row", out_pixel, {4'hF, 12'hFFF, 12'hFFF, 12'hFFF});
    pix(124, 50, 2'b00);
    chk("R5 first column past magnified edge", out_pixel, VID);
    pix(123, 58, 2'b00);
    chk("R5 first row past magnified edge", out_pixel, VID);
  endtask

  task automatic t_fmt32;
    setup(1, 0, 0, 1, 0, 0, 0, 2, 512, 1'b1);
    wr_cache(1, 128, 32'h8012_3456);
    wr_cache(1, 129, 32'h7FFF_FFFF);
    pix(0, 0, 2'b00);
    chk("R9 32-bit pixel widened", out_pixel, {4'hF, 12'h121, 12'h343, 12'h565});
    pix(1, 0, 2'b00);
    chk("R8 32-bit alpha clear passes video", out_pixel, VID);
  endtask

  task automatic t_overlap;
    setup(0, 0, 0, 3, 1, 0, 0, 1, 8, 1'b1);
    wr_cache(0, 2, 32'h0000_8000);
    wr_cache(1, 129, 32'hFF00_00FF);
    pix(0, 0, 2'b00);
    chk("R10 sprite 0 wins overlap", out_pixel, {4'hF, 36'd0});
    pix(1, 0, 2'b00);
    chk("R10 sprite 1 shows through transparent sprite 0", out_pixel, {4'hF, 12'h000, 12'h000, 12'hFFF});
  endtask

  task automatic t_ignored;
    wr_reg(0, 3, 32'hFFFF_FFFF);
    wr_reg(7, 0, 32'h0000_0000);
    wr_reg(7, 2, 32'h0000_0000);
    pix(0, 0, 2'b00);
    chk("R11 spare and absent slots ignored", out_pixel, {4'hF, 36'd0});
    wr_reg(0, 2, {1'b1, 13'd0, 2'd3, 4'd0, 12'd8});
    pix(0, 0, 2'b00);
    chk("R7 null format draws nothing", out_pixel, {4'hF, 12'h121, 12'h343, 12'h565});
  endtask

  task automatic t_wide;
    setup(0, 0, 100, 255, 0, 0, 0, 0, 0, 1'b1);
    wr_cache(0, 63, 32'hE000_0000);
    pix(255, 100, 2'b00);
    chk("R5 column 255 of a 256-wide sprite", out_pixel, {4'hF, 12'hFFF, 12'h000, 12'h000});
    pix(256, 100, 2'b00);
    chk("R5 column 256 outside", out_pixel, VID);
  endtask

  task automatic t_wrap;
    setup(0, 0, 200, 1, 0, 0, 0, 2, 4092, 1'b1);
    wr_cache(0, 0, 32'h8000_FF00);
    pix(1, 200, 2'b00);
    chk("R6 address wraps to word 0", out_pixel, {4'hF, 12'h000, 12'hFFF, 12'h000});
    wr_cache(0, 0, 32'h8000_00FF);
    pix(1, 200, 2'b00);
    chk("R12 rewritten cache word used", out_pixel, {4'hF, 12'h000, 12'h000, 12'hFFF});
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_hpos = 12'd500; in_vpos = 12'd500; in_pixel = VID; in_sync = 2'b01;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R3 stalled pixel present", out_pixel, VID);
    chk("R3 in_ready low during stall", {39'd0, in_ready}, 40'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 pixel held", out_pixel, VID);
    chk("R3 sync held", {38'd0, out_sync}, 40'd1);
    chk("R3 valid held", {39'd0, out_valid}, 40'd1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R3 drained after release", {39'd0, out_valid}, 40'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_passthrough();
    t_fmt16();
    t_fmt8_mag();
    t_fmt32();
    t_overlap();
    t_ignored();
    t_wide();
    t_wrap();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule